// File: doc/BRIEF.md
# Latched Interrupt Arbiter with Lock

This block sits between a set of interrupt sources and the CPU sequencer. Each hardware request line, and a separate software-interrupt request, is captured into its own pending latch, so a request only one cycle long is not lost. When the CPU strobes the start of interrupt processing, the arbiter picks one pending request and registers a constant vector code. The CPU uses that code to choose which vector to fetch.

Once a winner has been taken, the choice is frozen. A later request cannot replace it, whatever its priority, until the CPU reports that the handler has completed or the interrupt mask is cleared. On each grab the block raises a one-cycle request to set the CPU's interrupt mask. Hardware lines are maskable. The software interrupt is not.

Top module: `irq_arbiter`

## Requirements
- R1: After reset `vecValid` and `setMask` are 0, `vecIdx` is 0, and every pending latch is empty.
- R2: A request held high for a single cycle is latched. It is taken at a later `procStart` even though the line has returned low.
- R3: Arbitration happens only on a `procStart` cycle. Without `procStart`, `vecValid` stays 0 whatever is pending. `procStart` with an eligible pending request makes `vecValid` 1 one cycle later. Only requests latched before the `procStart` cycle take part.
- R4: The code encoding is: software interrupt = 0, hardware line i = i+1. The software interrupt beats all hardware lines. Among hardware lines, the lowest index wins.
- R5: While `maskBit` is 1, hardware lines are not eligible at `procStart`. A pending software interrupt is still taken.
- R6: While `vecValid` is 1, `vecIdx` does not change. Neither new requests nor further `procStart` strobes alter it.
- R7: `svcDone` while locked clears only the winner's pending latch, and drops `vecValid` one cycle later. Other pending requests remain.
- R8: `maskClr` while locked drops `vecValid` one cycle later and leaves the winner's latch pending. It is taken again at the next eligible `procStart`. If `svcDone` arrives in the same cycle, `svcDone` takes precedence and the latch is cleared.
- R9: `setMask` is a one-cycle pulse, asserted in the same cycle that `vecValid` rises.
- R10: A line still high when `svcDone` clears its latch is latched again, and it wins again at the next `procStart`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_IRQ | Maskable hardware request lines |
| swiReq | input | 1 | Software-interrupt request (not maskable) |
| maskBit | input | 1 | CPU interrupt-mask bit |
| procStart | input | 1 | Start-of-interrupt-processing strobe |
| svcDone | input | 1 | Return-from-interrupt strobe (winner serviced) |
| maskClr | input | 1 | Mask-clear strobe (releases the lock) |
| vecIdx | output | $clog2(NUM_IRQ+1) | Latched vector code |
| vecValid | output | 1 | Vector code is locked and valid |
| setMask | output | 1 | One-cycle request to set the CPU mask |

## Verification
The bench builds the arbiter with NUM_IRQ = 4, which gives a 3-bit vector code. This small size lets it sweep all 64 combinations of hardware lines, software request and mask bit. For each combination the expected code is computed arithmetically in the bench. Directed sequences then cover the following:
- pre-emption attempts during the lock;
- release by service and by mask clear;
- re-arbitration of a request that stays asserted.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  // Strobes from the lock controller to the datapath
  typedef struct packed {
    logic grab;      // take the current arbitration result
    logic clearWin;  // winner serviced: clear its pending latch
    logic freeLock;  // lock released
  } ctlStrobe_t;
endpackage

// File: rtl/irqarb_datapath.sv
module irqarb_datapath
  import irqarb_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int CODE_W  = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               swiReq,
  input  logic               maskBit,
  input  ctlStrobe_t         ctl,
  output logic               anyEligible,
  output logic [CODE_W-1:0]  winCode
);
  logic [NUM_IRQ-1:0] hwPend;
  logic               swiPend;
  logic [CODE_W-1:0]  hwSel;
  logic               hwAny;
  logic [NUM_IRQ-1:0] clrHw;
  logic               clrSwi;

  // Fixed priority: the lowest pending index wins
  always_comb begin
    hwSel = '0;
    hwAny = 1'b0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (hwPend[i]) begin
        hwSel = CODE_W'(i + 1);
        hwAny = 1'b1;
      end
    end
  end

  assign anyEligible = swiPend | (hwAny & ~maskBit);

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_clr
      assign clrHw[g] = ctl.clearWin && (winCode == CODE_W'(g + 1));
    end
  endgenerate
  assign clrSwi = ctl.clearWin && (winCode == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwPend  <= '0;
      swiPend <= 1'b0;
      winCode <= '0;
    end else begin
      hwPend  <= (hwPend & ~clrHw) | irqReq;
      swiPend <= (swiPend & ~clrSwi) | swiReq;
      if (ctl.grab) winCode <= swiPend ? '0 : hwSel;
    end
  end

  // R4: a pending software interrupt always takes code 0
  assert_swi_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.grab && swiPend) |=> (winCode == '0));
  // R5: a hardware grab can only happen while unmasked
  assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.grab && !swiPend) |-> !maskBit);
  // R7: servicing the software winner empties its latch
  assert_swi_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clearWin && winCode == '0 && !swiReq) |=> !swiPend);
endmodule

// File: rtl/irqarb_control.sv
module irqarb_control
  import irqarb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       procStart,
  input  logic       svcDone,
  input  logic       maskClr,
  input  logic       anyEligible,
  output ctlStrobe_t ctl,
  output logic       locked,
  output logic       setMask
);
  always_comb begin
    ctl.grab     = procStart && !locked && anyEligible;
    ctl.clearWin = locked && svcDone;
    ctl.freeLock = locked && (svcDone || maskClr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b0;
      setMask <= 1'b0;
    end else begin
      if (ctl.grab) locked <= 1'b1;
      else if (ctl.freeLock) locked <= 1'b0;
      setMask <= ctl.grab;
    end
  end

  // R3: the lock is only taken on a processing-start strobe
  assert_start_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !procStart) |=> !locked);
  // R6: the lock holds until service or mask clear
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !svcDone && !maskClr) |=> locked);
  // R7/R8: service or mask clear drops the lock
  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (locked && (svcDone || maskClr)) |=> !locked);
  // R9: set-mask request is a single-cycle pulse
  assert_setmask_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    setMask |=> !setMask);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irqarb_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int CODE_W = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               swiReq,
  input  logic               maskBit,
  input  logic               procStart,
  input  logic               svcDone,
  input  logic               maskClr,
  output logic [CODE_W-1:0]  vecIdx,
  output logic               vecValid,
  output logic               setMask
);
  ctlStrobe_t ctl;
  logic       anyEligible;

  irqarb_control u_ctrl (
    .clk(clk), .rstN(rstN), .procStart(procStart), .svcDone(svcDone),
    .maskClr(maskClr), .anyEligible(anyEligible), .ctl(ctl),
    .locked(vecValid), .setMask(setMask)
  );

  irqarb_datapath #(.NUM_IRQ(NUM_IRQ), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .swiReq(swiReq),
    .maskBit(maskBit), .ctl(ctl), .anyEligible(anyEligible),
    .winCode(vecIdx)
  );

  // R9: the set-mask pulse coincides with a rising lock
  assert_setmask_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    setMask |-> (vecValid && !$past(vecValid)));
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  localparam int N = 4;
  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] irqReq = '0;
  logic swiReq = 0, maskBit = 0, procStart = 0, svcDone = 0, maskClr = 0;
  logic [2:0] vecIdx;
  logic vecValid, setMask;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_arbiter #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .swiReq(swiReq),
    .maskBit(maskBit), .procStart(procStart), .svcDone(svcDone),
    .maskClr(maskClr), .vecIdx(vecIdx), .vecValid(vecValid), .setMask(setMask)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; irqReq = '0; swiReq = 0; maskBit = 0;
    procStart = 0; svcDone = 0; maskClr = 0;
    step(); step();
    rstN = 1;
  endtask

  task automatic start();
    procStart = 1; step(); procStart = 0;
  endtask

  task automatic service();
    svcDone = 1; step(); svcDone = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 vecValid", vecValid, 0);
    check("R1 setMask", setMask, 0);
    check("R1 vecIdx", vecIdx, 0);
    start();
    check("R1 nothing pending", vecValid, 0);

    // Exhaustive sweep: R2 R3 R4 R5 R9
    for (int p = 0; p < 64; p++) begin
      int expCode;
      int expV;
      doReset();
      irqReq = p[3:0]; swiReq = p[4]; maskBit = p[5];
      step();
      irqReq = '0; swiReq = 0;
      step();
      check("R3 no start no valid", vecValid, 0);
      expV = 0; expCode = 0;
      if (p[4]) begin
        expV = 1; expCode = 0;
      end else if (!p[5]) begin
        for (int i = N - 1; i >= 0; i--)
          if (p[i]) begin expV = 1; expCode = i + 1; end
      end
      start();
      check("R2/R3/R5 valid", vecValid, expV);
      if (expV == 1) check("R4 code", vecIdx, expCode);
      check("R9 setMask pulse", setMask, expV);
      step();
      check("R9 setMask falls", setMask, 0);
      check("R6 still locked", vecValid, expV);
    end

    // R3: a request on the strobe cycle is not arbitrated
    doReset();
    irqReq = 4'b0100; procStart = 1; step(); procStart = 0; irqReq = '0;
    check("R3 same-cycle request ignored", vecValid, 0);
    start();
    check("R3 latched then taken", vecIdx, 3);

    // Directed lock sequence
    doReset();
    irqReq = 4'b1000; step(); irqReq = '0;
    start();
    check("R4 line3 code", vecIdx, 4);
    irqReq = 4'b0001; swiReq = 1; step(); irqReq = '0; swiReq = 0;
    start();
    check("R6 no preempt valid", vecValid, 1);
    check("R6 no preempt code", vecIdx, 4);
    service();
    check("R7 release", vecValid, 0);
    start();
    check("R7 others kept, swi wins", vecIdx, 0);
    check("R7 others kept valid", vecValid, 1);
    maskClr = 1; step(); maskClr = 0;
    check("R8 maskClr releases", vecValid, 0);
    start();
    check("R8 winner still pending", vecValid, 1);
    check("R8 winner code", vecIdx, 0);
    service();
    start();
    check("R7 next is line0", vecIdx, 1);
    service();
    start();
    check("R7 line3 was cleared", vecValid, 0);

    // R8: svcDone and maskClr together clear the latch
    doReset();
    irqReq = 4'b0010; step(); irqReq = '0;
    start();
    svcDone = 1; maskClr = 1; step(); svcDone = 0; maskClr = 0;
    check("R8 both strobes release", vecValid, 0);
    start();
    check("R8 svcDone wins, latch cleared", vecValid, 0);

    // R10: persistent request is arbitrated again
    doReset();
    irqReq = 4'b0100; step();
    start();
    check("R10 first win", vecIdx, 3);
    service();
    start();
    check("R10 rearbitrated valid", vecValid, 1);
    check("R10 rearbitrated code", vecIdx, 3);
    irqReq = '0;
    service();
    start();
    check("R10 dropped request gone", vecValid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule